// File: doc/BRIEF.md
# Software-Generated Interrupt Target Dispatcher

This block takes a 64-bit write to an interrupt-generation register, together with the index of the CPU that made the write. From that write it picks out an interrupt number, the three upper affinity levels of the targets, a 16-bit mask of level-0 CPU numbers and a routing-mode bit. It then walks a table of per-CPU affinity values, one entry per clock, in ascending index order. For every CPU selected by the request, it sets that CPU's pending flag for the requested interrupt number.

In targeted mode, a CPU is selected when its upper affinity levels equal the requested ones and its level-0 bit is set in the mask. Each CPU that is served has its bit removed from a working copy of the mask, and the walk stops as soon as that copy is empty. In broadcast mode, every CPU except the sender is selected. When at least one CPU was signalled, the block emits a one-cycle state-update pulse followed by a one-cycle kick pulse.

While a dispatch is in progress the block reports busy. Any further request during that time is dropped and flagged, so no other dispatch can interleave with it. Pending flags are cleared through a separate acknowledge input. The affinity table is written through a configuration port while the block is idle.

Top module: `sgi_dispatch`

## Requirements
- R1: The request fields are decoded from `reqData` as follows: target mask in [15:0], affinity level 1 in [23:16], interrupt number in [27:24], affinity level 2 in [39:32], routing-mode bit in [40], and affinity level 3 in [55:48]. Setting any other bit has no effect.
- R2: With the routing-mode bit at 0, CPU c is signalled only when all of the following hold: its table levels 3, 2 and 1 equal the requested ones, its level-0 value is below 16, and mask bit [level0] is set. A table entry is written as {level3, level2, level1, level0}, with level 3 in the most significant byte.
- R3: With the routing-mode bit at 1, every CPU except `reqCpu` is signalled, and the affinity fields and mask are ignored.
- R4: One table entry is visited per cycle, in ascending order, starting in the cycle after acceptance. In targeted mode the walk ends in the cycle that removes the last mask bit. A request whose mask is zero ends after one cycle.
- R5: Signalling sets bit `pending[c*16 + intid]`. A set flag stays set until an acknowledge (`ackValid`, `ackCpu`, `ackSgi`) clears it on the next edge. If a set and an acknowledge hit the same flag in the same cycle, the set wins.
- R6: If any CPU was signalled, `stateUpdate` pulses for one cycle right after the walk ends, and `kick` pulses in the following cycle. Otherwise neither pulse occurs.
- R7: `busy` is high from the cycle after a request is accepted through the walk and any update and kick cycles. A request raised while `busy` is high is ignored, and `reqError` is high in that same cycle.
- R8: A targeted request that matches no CPU visits all entries and signals nothing.
- R9: A configuration write (`cfgWe`, `cfgIdx`, `cfgAff`) updates the table only while `busy` is low. A configuration write made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request write strobe |
| reqData | input | 64 | Request register value |
| reqCpu | input | CPU_W | Index of the requesting CPU |
| cfgWe | input | 1 | Affinity table write strobe |
| cfgIdx | input | CPU_W | Table entry to write |
| cfgAff | input | 32 | Affinity value {L3,L2,L1,L0} |
| ackValid | input | 1 | Acknowledge strobe |
| ackCpu | input | CPU_W | CPU of the flag to clear |
| ackSgi | input | 4 | Interrupt number of the flag to clear |
| pending | output | NUM_CPUS*16 | Pending flags, bit c*16+intid |
| busy | output | 1 | Dispatch in progress |
| reqError | output | 1 | Request dropped because the block was busy |
| stateUpdate | output | 1 | State-update pulse |
| kick | output | 1 | Kick pulse |

## Verification
The assertions assume that `reqValid` and `cfgWe` are ordinary single-cycle strobes sampled at the clock edge, and that `ackCpu` names an existing CPU. They also assume that the pending flags change only through the dispatch walk or an acknowledge. The stimulus drives every input at the falling edge and holds each strobe for exactly one cycle. Acknowledges target only CPUs in the table, so these conditions hold throughout. Requests issued during busy are deliberate, so that the rejection path is exercised while the invariants are checked.

// File: rtl/sgi_dispatch_pkg.sv
package sgi_dispatch_pkg;
  localparam int SGI_W  = 4;
  localparam int MASK_W = 16;
  localparam int AFF_W  = 8;
  localparam int NUM_SGI = 1 << SGI_W;

  typedef struct packed {
    logic load;
    logic step;
    logic cfgWr;
  } ctrlStrobe_t;

  typedef struct packed {
    logic stopNow;
    logic hitNext;
  } scanStatus_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_UPDATE, ST_KICK} scanState_t;
endpackage

// File: rtl/sgi_datapath.sv
module sgi_datapath
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrlStrobe_t                 strobe,
  input  logic [63:0]                 reqData,
  input  logic [CPU_W-1:0]            reqCpu,
  input  logic [CPU_W-1:0]            cfgIdx,
  input  logic [4*AFF_W-1:0]          cfgAff,
  input  logic                        ackValid,
  input  logic [CPU_W-1:0]            ackCpu,
  input  logic [SGI_W-1:0]            ackSgi,
  output scanStatus_t                 status,
  output logic [NUM_CPUS*NUM_SGI-1:0] pending
);
  localparam logic [CPU_W-1:0] LAST_IDX = CPU_W'(NUM_CPUS - 1);

  logic [4*AFF_W-1:0] affTab [NUM_CPUS];
  logic [SGI_W-1:0]   reqSgi;
  logic               reqBcast;
  logic [3*AFF_W-1:0] reqAff;
  logic [CPU_W-1:0]   reqSender;
  logic [MASK_W-1:0]  workMask;
  logic [CPU_W-1:0]   idx;
  logic               hit;

  logic [4*AFF_W-1:0] entry;
  logic               inMaskRange;
  logic               matchTgt;
  logic               matchBc;
  logic               selNow;
  logic               isLast;
  logic [MASK_W-1:0]  entryBit;
  logic [MASK_W-1:0]  newMask;

  always_comb begin
    entry       = affTab[idx];
    inMaskRange = entry[AFF_W-1:0] < AFF_W'(MASK_W);
    entryBit    = inMaskRange ? (MASK_W'(1) << entry[3:0]) : '0;
    matchTgt    = (entry[4*AFF_W-1:AFF_W] == reqAff) && ((workMask & entryBit) != '0);
    matchBc     = (idx != reqSender);
    selNow      = strobe.step && (reqBcast ? matchBc : matchTgt);
    newMask     = matchTgt ? (workMask & ~entryBit) : workMask;
    isLast      = (idx == LAST_IDX);
    status.hitNext = hit || selNow;
    status.stopNow = reqBcast ? isLast
                              : (isLast || (workMask == '0) || (newMask == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqSgi    <= '0;
      reqBcast  <= 1'b0;
      reqAff    <= '0;
      reqSender <= '0;
      workMask  <= '0;
      idx       <= '0;
      hit       <= 1'b0;
    end else if (strobe.load) begin
      reqSgi    <= reqData[27:24];
      reqBcast  <= reqData[40];
      reqAff    <= {reqData[55:48], reqData[39:32], reqData[23:16]};
      reqSender <= reqCpu;
      workMask  <= reqData[15:0];
      idx       <= '0;
      hit       <= 1'b0;
    end else if (strobe.step) begin
      if (!reqBcast) workMask <= newMask;
      if (!isLast) idx <= idx + 1'b1;
      hit <= status.hitNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPUS; c++) affTab[c] <= '0;
    end else if (strobe.cfgWr) begin
      affTab[cfgIdx] <= cfgAff;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpuRow
    logic rowSel;
    logic rowAck;
    assign rowSel = selNow && (idx == CPU_W'(c));
    assign rowAck = ackValid && (ackCpu == CPU_W'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[c*NUM_SGI +: NUM_SGI] <= '0;
      end else begin
        for (int s = 0; s < NUM_SGI; s++) begin
          if (rowSel && (reqSgi == SGI_W'(s)))
            pending[c*NUM_SGI + s] <= 1'b1;
          else if (rowAck && (ackSgi == SGI_W'(s)))
            pending[c*NUM_SGI + s] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sgi_control.sv
module sgi_control
  import sgi_dispatch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        cfgWe,
  input  scanStatus_t status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        reqError,
  output logic        stateUpdate,
  output logic        kick
);
  scanState_t state, stateNext;

  always_comb begin
    busy         = (state != ST_IDLE);
    strobe.load  = reqValid && !busy;
    strobe.step  = (state == ST_SCAN);
    strobe.cfgWr = cfgWe && !busy;
    reqError     = reqValid && busy;
    stateUpdate  = (state == ST_UPDATE);
    kick         = (state == ST_KICK);
    stateNext    = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_SCAN;
      ST_SCAN:   if (status.stopNow) stateNext = status.hitNext ? ST_UPDATE : ST_IDLE;
      ST_UPDATE: stateNext = ST_KICK;
      ST_KICK:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reqValid,
  input  logic [63:0]                 reqData,
  input  logic [CPU_W-1:0]            reqCpu,
  input  logic                        cfgWe,
  input  logic [CPU_W-1:0]            cfgIdx,
  input  logic [31:0]                 cfgAff,
  input  logic                        ackValid,
  input  logic [CPU_W-1:0]            ackCpu,
  input  logic [3:0]                  ackSgi,
  output logic [NUM_CPUS*16-1:0]      pending,
  output logic                        busy,
  output logic                        reqError,
  output logic                        stateUpdate,
  output logic                        kick
);
  ctrlStrobe_t strobe;
  scanStatus_t status;

  sgi_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .cfgWe(cfgWe),
    .status(status), .strobe(strobe), .busy(busy), .reqError(reqError),
    .stateUpdate(stateUpdate), .kick(kick)
  );

  sgi_datapath #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqData(reqData),
    .reqCpu(reqCpu), .cfgIdx(cfgIdx), .cfgAff(cfgAff), .ackValid(ackValid),
    .ackCpu(ackCpu), .ackSgi(ackSgi), .status(status), .pending(pending)
  );
endmodule

// File: rtl/sgi_dispatch_checker.sv
module sgi_dispatch_checker #(
  parameter int NUM_CPUS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reqValid,
  input logic                   busy,
  input logic                   reqError,
  input logic                   stateUpdate,
  input logic                   kick,
  input logic [NUM_CPUS*16-1:0] pending
);
  assert_kick_follows_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stateUpdate |=> kick);
  assert_kick_needs_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> $past(stateUpdate));
  assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stateUpdate, kick}));
  assert_error_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reqError |-> busy);
  assert_accept_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !busy) |=> busy);
  assert_pulse_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stateUpdate || kick) |-> busy);
  assert_set_only_in_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~$past(pending)) != '0) |-> $past(busy));
endmodule

bind sgi_dispatch sgi_dispatch_checker #(.NUM_CPUS(NUM_CPUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .busy(busy),
  .reqError(reqError), .stateUpdate(stateUpdate), .kick(kick), .pending(pending)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [63:0] reqData = '0;
  logic [CW-1:0] reqCpu = '0;
  logic cfgWe = 1'b0;
  logic [CW-1:0] cfgIdx = '0;
  logic [31:0] cfgAff = '0;
  logic ackValid = 1'b0;
  logic [CW-1:0] ackCpu = '0;
  logic [3:0] ackSgi = '0;
  logic [N*16-1:0] pending;
  logic busy, reqError, stateUpdate, kick;

  int checks = 0;
  int errors = 0;
  logic [31:0] tbAff [N];
  logic [N*16-1:0] expPend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgi_dispatch #(.NUM_CPUS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqData(reqData),
    .reqCpu(reqCpu), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgAff(cfgAff),
    .ackValid(ackValid), .ackCpu(ackCpu), .ackSgi(ackSgi), .pending(pending),
    .busy(busy), .reqError(reqError), .stateUpdate(stateUpdate), .kick(kick)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] a3, input logic [7:0] a2, input logic [7:0] a1,
                                     input logic [3:0] sgi, input logic irm, input logic [15:0] mask);
    return {8'h00, a3, 7'h00, irm, a2, 4'h0, sgi, a1, mask};
  endfunction

  task automatic model(input logic [63:0] d, input int sender, output logic [N-1:0] tgt, output int cycles);
    logic [15:0] work;
    logic [23:0] aff;
    work = d[15:0];
    aff = {d[55:48], d[39:32], d[23:16]};
    tgt = '0;
    cycles = 0;
    if (d[40]) begin
      for (int c = 0; c < N; c++) if (c != sender) tgt[c] = 1'b1;
      cycles = N;
    end else begin
      for (int c = 0; c < N; c++) begin
        cycles = c + 1;
        if (work == 0) break;
        if (tbAff[c][31:8] == aff && tbAff[c][7:0] < 16 && work[tbAff[c][3:0]]) begin
          tgt[c] = 1'b1;
          work[tbAff[c][3:0]] = 1'b0;
          if (work == 0) break;
        end
      end
    end
  endtask

  task automatic waitDone(output int n, output int upd, output int updAt, output int kk, output int kAt);
    n = 0; upd = 0; updAt = -1; kk = 0; kAt = -1;
    while (busy && n < 100) begin
      n++;
      if (stateUpdate) begin upd++; updAt = n; end
      if (kick) begin kk++; kAt = n; end
      @(negedge clk);
    end
  endtask

  task automatic doReq(input logic [63:0] d, input int sender, input string req);
    logic [N-1:0] tgt;
    int cyc, n, upd, updAt, kk, kAt, hit;
    model(d, sender, tgt, cyc);
    hit = (tgt != 0) ? 1 : 0;
    @(negedge clk);
    reqValid = 1'b1; reqData = d; reqCpu = CW'(sender);
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(n, upd, updAt, kk, kAt);
    for (int c = 0; c < N; c++) if (tgt[c]) expPend[c*16 + int'(d[27:24])] = 1'b1;
    check(pending == expPend, {req, " pending"}, pending, expPend);
    check(n == cyc + 2*hit, "R4 busy length", n, cyc + 2*hit);
    check(upd == hit && kk == hit, "R6 pulse count", {upd, kk}, {hit, hit});
    if (hit != 0) check(kAt == updAt + 1 && updAt == cyc + 1, "R6 pulse order", {updAt, kAt}, {cyc + 1, cyc + 2});
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin
      tbAff[c] = {8'h00, 8'h01, 8'(c >> 2), 8'(c & 3)};
    end
    tbAff[7] = {8'h00, 8'h01, 8'h01, 8'h13};
    repeat (3) @(negedge clk);
    check(pending == '0 && !busy && !stateUpdate && !kick && !reqError, "R7 reset state",
          {pending[N*16-1:0]}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < N; c++) begin
      @(negedge clk);
      cfgWe = 1'b1; cfgIdx = CW'(c); cfgAff = tbAff[c];
    end
    @(negedge clk);
    cfgWe = 1'b0;

    // R2 R4 targeted sweeps
    for (int a1 = 0; a1 < 2; a1++) begin
      logic [15:0] masks [6] = '{16'h0001, 16'h000F, 16'h0005, 16'h0008, 16'h0000, 16'hFFFF};
      for (int m = 0; m < 6; m++)
        doReq(mk(8'h00, 8'h01, 8'(a1), 4'(m + 4*a1), 1'b0, masks[m]), 0, "R2 targeted");
    end
    // R8 no match
    doReq(mk(8'h00, 8'h02, 8'h00, 4'd14, 1'b0, 16'hFFFF), 1, "R8 no match");
    doReq(mk(8'h00, 8'h01, 8'h01, 4'd14, 1'b0, 16'h0010), 1, "R8 mask beyond CPUs");
    // R1 ignored bits set
    doReq(mk(8'h00, 8'h01, 8'h01, 4'd13, 1'b0, 16'h0002) | 64'hFF00_FE00_F000_0000, 2, "R1 ignored bits");
    // R3 broadcast from every sender with garbage affinity
    for (int s = 0; s < N; s++)
      doReq(mk(8'hAA, 8'h55, 8'h77, 4'(s), 1'b1, 16'h0000), s, "R3 broadcast");

    // R5 single acknowledge
    @(negedge clk);
    ackValid = 1'b1; ackCpu = 3'd2; ackSgi = 4'd0;
    @(negedge clk);
    ackValid = 1'b0;
    expPend[2*16 + 0] = 1'b0;
    check(pending == expPend, "R5 ack clears one flag", pending, expPend);

    // R5 set wins over acknowledge on same flag (cpu0, sgi 3 already set)
    check(pending[3] == 1'b1, "R5 precondition", pending[3], 1);
    @(negedge clk);
    reqValid = 1'b1; reqData = mk(8'h00, 8'h01, 8'h00, 4'd3, 1'b0, 16'h0001); reqCpu = 3'd5;
    @(negedge clk);
    reqValid = 1'b0; ackValid = 1'b1; ackCpu = 3'd0; ackSgi = 4'd3;
    @(negedge clk);
    ackValid = 1'b0;
    while (busy) @(negedge clk);
    check(pending == expPend, "R5 set wins collision", pending, expPend);

    // R7 R9 request and config write while busy are dropped
    @(negedge clk);
    reqValid = 1'b1; reqData = mk(8'h00, 8'h01, 8'h00, 4'd9, 1'b1, 16'h0); reqCpu = 3'd0;
    @(negedge clk);
    reqData = mk(8'h00, 8'h01, 8'h00, 4'd10, 1'b0, 16'h0001);
    cfgWe = 1'b1; cfgIdx = 3'd0; cfgAff = {8'h00, 8'h01, 8'h03, 8'h00};
    #1;
    check(reqError == 1'b1 && busy == 1'b1, "R7 error while busy", {reqError, busy}, 2'b11);
    @(negedge clk);
    reqValid = 1'b0; cfgWe = 1'b0;
    #1;
    check(reqError == 1'b0, "R7 error is a pulse", reqError, 0);
    while (busy) @(negedge clk);
    for (int c = 1; c < N; c++) expPend[c*16 + 9] = 1'b1;
    check(pending == expPend, "R7 busy request ignored", pending, expPend);
    doReq(mk(8'h00, 8'h01, 8'h00, 4'd11, 1'b0, 16'h0001), 3, "R9 busy cfg ignored");

    // R5 clear everything through acknowledges
    for (int c = 0; c < N; c++)
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        ackValid = 1'b1; ackCpu = CW'(c); ackSgi = 4'(s);
      end
    @(negedge clk);
    ackValid = 1'b0;
    expPend = '0;
    check(pending == '0, "R5 ack sweep clears all", pending, 0);

    // R9 idle config write takes effect
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 3'd6; cfgAff = {8'h00, 8'h01, 8'h03, 8'h02};
    tbAff[6] = cfgAff;
    @(negedge clk);
    cfgWe = 1'b0;
    doReq(mk(8'h00, 8'h01, 8'h03, 4'd6, 1'b0, 16'h0004), 0, "R9 idle cfg write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule